// File: doc/BRIEF.md
# Serial Input-State Frame Transmitter

This block is a read-only serial slave. It reports the levels of a bank of already-filtered digital inputs, together with two alarm flags, to a host controller. The host pulls chip select low. The block then takes a snapshot of the inputs and the alarms and shifts a frame out, most significant bit first, on the host's serial clock. The bus uses clock polarity 0 and clock phase 0: the clock idles low, the host samples on the rising edge, and the block changes its output after each falling edge.

A static mode pin chooses between two frame lengths. The short frame is eight bits and carries only the input levels. The long frame is sixteen bits and adds a control byte. That byte holds the two alarms written active low, four pair-parity check bits and a fixed `01` trailer, so the host can detect a corrupted transfer. Chip select and the serial clock are both sampled into the system clock domain through two-flop synchronizers, and all edge detection is done there.

Top module: `sfs_spi_status_tx`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `miso_oe_o` is 0 and `miso_o` is 0.
- R2: Whenever `miso_oe_o` is 0, `miso_o` is 0. At most three system clocks after chip select rises, `miso_oe_o` is 0.
- R3: At most three system clocks after chip select falls, `miso_oe_o` is 1 and `miso_o` shows frame bit 15, which is `in_state_i[7]`.
- R4: `miso_o` changes only after a falling edge of `sck_i`. It holds its value from each rising edge of `sck_i` to the next falling edge.
- R5: In the long frame (`frame_short_i`=0), frame bits 15 down to 8 are `in_state_i[7]` down to `in_state_i[0]`.
- R6: Long frame bit 7 is the inverse of `uv_alarm_i` and bit 6 is the inverse of `ot_alarm_i`, so an active alarm is sent as 0.
- R7: Long frame bits 5, 4, 3 and 2 are the XOR of input pairs (7,6), (5,4), (3,2) and (1,0) respectively. Each pair plus its check bit therefore has even parity.
- R8: Long frame bit 1 is 0 and bit 0 is 1.
- R9: With `frame_short_i`=1, only frame bits 15 to 8 (the inputs) are sent, and every later bit is 0.
- R10: Serial clocks beyond the frame length shift out 0.
- R11: Inputs and alarms are captured once, when chip select falls. Changes on them during a frame do not alter the bits sent.
- R12: If chip select rises before the frame ends, shifting stops and the output is released. The next frame starts again from bit 15 with a fresh capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select from the host, active low, asynchronous |
| sck_i | input | 1 | Serial clock from the host, asynchronous |
| frame_short_i | input | 1 | Static mode: 1 selects the 8-bit frame, 0 the 16-bit frame |
| in_state_i | input | N_IN (8) | Filtered input levels; bit i is input i+1 |
| uv_alarm_i | input | 1 | Undervoltage alarm, active high, synchronous |
| ot_alarm_i | input | 1 | Overtemperature alarm, active high, synchronous |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Output enable for the data pad; 0 means high impedance |

## Verification
The assertions assume that `frame_short_i` does not change while a frame is in progress. They also assume that each level of the serial clock lasts more than three system clocks, so every clock edge is detected after synchronization and the shifted bit settles before the next rising edge. The inputs and alarms are taken to be synchronous to `clk`. The bench drives every input on the falling edge of `clk`. It holds the mode pin fixed for the whole of each frame and keeps each serial-clock level for six system clocks. Chip select changes only while the serial clock is low.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int N_ALARM   = 2;
  localparam int N_TRAILER = 2;
  localparam logic [N_TRAILER-1:0] TRAILER_PAT = 2'b01;

  function automatic logic pair_parity(input logic a, input logic b);
    return a ^ b;
  endfunction
endpackage

// File: rtl/sfs_sync.sv
module sfs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sfs_edge.sv
module sfs_edge #(
  parameter logic FALLING = 1'b1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic pulse
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= level;
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse = prev & ~level;
    end else begin : g_rise
      assign pulse = ~prev & level;
    end
  endgenerate
endmodule

// File: rtl/sfs_frame_build.sv
module sfs_frame_build
  import sfs_pkg::*;
#(
  parameter int N_IN    = 8,
  parameter int FRAME_W = N_IN + N_ALARM + N_IN/2 + N_TRAILER
) (
  input  logic [N_IN-1:0]    din,
  input  logic               uv_alarm,
  input  logic               ot_alarm,
  input  logic               short_mode,
  output logic [FRAME_W-1:0] frame
);
  localparam int N_PC   = N_IN / 2;
  localparam int PC_LSB = N_TRAILER;
  localparam int OT_POS = PC_LSB + N_PC;
  localparam int UV_POS = OT_POS + 1;

  logic [FRAME_W-1:0] long_frame;
  logic [N_PC-1:0]    pc;

  generate
    for (genvar k = 0; k < N_PC; k++) begin : g_pc
      assign pc[k] = pair_parity(din[N_IN-1-2*k], din[N_IN-2-2*k]);
      assign long_frame[PC_LSB + N_PC - 1 - k] = pc[k];
    end
  endgenerate

  assign long_frame[FRAME_W-1 -: N_IN]   = din;
  assign long_frame[UV_POS]              = ~uv_alarm;
  assign long_frame[OT_POS]              = ~ot_alarm;
  assign long_frame[N_TRAILER-1:0]       = TRAILER_PAT;

  always_comb begin
    if (short_mode) frame = {din, {(FRAME_W-N_IN){1'b0}}};
    else            frame = long_frame;
  end
endmodule

// File: rtl/sfs_shifter.sv
module sfs_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               stop,
  input  logic               shift,
  input  logic [FRAME_W-1:0] frame,
  output logic               miso,
  output logic               oe
);
  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
      oe <= 1'b0;
    end else if (stop) begin
      sr <= '0;
      oe <= 1'b0;
    end else if (load) begin
      sr <= frame;
      oe <= 1'b1;
    end else if (shift && oe) begin
      sr <= {sr[FRAME_W-2:0], 1'b0};
    end
  end

  assign miso = sr[FRAME_W-1];
endmodule

// File: rtl/sfs_spi_status_tx.sv
module sfs_spi_status_tx
  import sfs_pkg::*;
#(
  parameter int N_IN        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_n_i,
  input  logic            sck_i,
  input  logic            frame_short_i,
  input  logic [N_IN-1:0] in_state_i,
  input  logic            uv_alarm_i,
  input  logic            ot_alarm_i,
  output logic            miso_o,
  output logic            miso_oe_o
);
  localparam int FRAME_W = N_IN + N_ALARM + N_IN/2 + N_TRAILER;

  logic cs_n_s, sck_s;
  logic cs_fall_w, cs_rise_w, sck_fall_w;
  logic [FRAME_W-1:0] frame_w;

  sfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .d(cs_n_i), .q(cs_n_s));

  sfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst(rst), .d(sck_i), .q(sck_s));

  sfs_edge #(.FALLING(1'b1), .RST_VAL(1'b1)) u_cs_fall (
    .clk(clk), .rst(rst), .level(cs_n_s), .pulse(cs_fall_w));

  sfs_edge #(.FALLING(1'b0), .RST_VAL(1'b1)) u_cs_rise (
    .clk(clk), .rst(rst), .level(cs_n_s), .pulse(cs_rise_w));

  sfs_edge #(.FALLING(1'b1), .RST_VAL(1'b0)) u_sck_fall (
    .clk(clk), .rst(rst), .level(sck_s), .pulse(sck_fall_w));

  sfs_frame_build #(.N_IN(N_IN), .FRAME_W(FRAME_W)) u_build (
    .din(in_state_i), .uv_alarm(uv_alarm_i), .ot_alarm(ot_alarm_i),
    .short_mode(frame_short_i), .frame(frame_w));

  sfs_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .load(cs_fall_w), .stop(cs_rise_w),
    .shift(sck_fall_w), .frame(frame_w), .miso(miso_o), .oe(miso_oe_o));
endmodule

// File: rtl/sfs_spi_status_tx_chk.sv
module sfs_spi_status_tx_chk #(
  parameter int N_IN    = 8,
  parameter int FRAME_W = 16
) (
  input logic clk,
  input logic rst,
  input logic short_frame,
  input logic din_msb,
  input logic miso,
  input logic miso_oe,
  input logic cs_fall,
  input logic cs_rise,
  input logic sck_fall
);
  logic [5:0] cnt;
  localparam logic [5:0] C_BIT1  = 6'(FRAME_W - 3);
  localparam logic [5:0] C_BIT0  = 6'(FRAME_W - 2);
  localparam logic [5:0] C_LTAIL = 6'(FRAME_W - 1);
  localparam logic [5:0] C_STAIL = 6'(N_IN - 1);

  always_ff @(posedge clk) begin
    if (rst || cs_fall) cnt <= '0;
    else if (sck_fall && miso_oe && cnt != 6'h3f) cnt <= cnt + 6'd1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !miso_oe && !miso); // R1
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst) !miso_oe |-> !miso); // R2
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst) cs_rise |=> !miso_oe); // R2
  AST_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> miso_oe && (miso == $past(din_msb))); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    miso_oe && !sck_fall && !cs_rise |=> $stable(miso)); // R4
  AST_TRAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
    miso_oe && sck_fall && !cs_rise && !short_frame && cnt == C_BIT1 |=> !miso); // R8
  AST_TRAIL_ONE: assert property (@(posedge clk) disable iff (rst)
    miso_oe && sck_fall && !cs_rise && !short_frame && cnt == C_BIT0 |=> miso); // R8
  AST_LONG_TAIL: assert property (@(posedge clk) disable iff (rst)
    miso_oe && sck_fall && !short_frame && cnt >= C_LTAIL |=> !miso); // R10
  AST_SHORT_TAIL: assert property (@(posedge clk) disable iff (rst)
    miso_oe && sck_fall && short_frame && cnt >= C_STAIL |=> !miso); // R9
endmodule

bind sfs_spi_status_tx sfs_spi_status_tx_chk #(.N_IN(N_IN), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst(rst), .short_frame(frame_short_i), .din_msb(in_state_i[N_IN-1]),
  .miso(miso_o), .miso_oe(miso_oe_o), .cs_fall(cs_fall_w), .cs_rise(cs_rise_w),
  .sck_fall(sck_fall_w));

// File: tb/sfs_spi_status_tx_tb_top.sv
module sfs_spi_status_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 6;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, short_m = 1'b0;
  logic [7:0] din = 8'h00;
  logic uv = 1'b0, ot = 1'b0;
  logic miso, miso_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic v; string tag; } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sfs_spi_status_tx dut_i (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sck_i(sck), .frame_short_i(short_m),
    .in_state_i(din), .uv_alarm_i(uv), .ot_alarm_i(ot),
    .miso_o(miso), .miso_oe_o(miso_oe));

  task automatic check(input bit ok, input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] long_frame(input logic [7:0] d, input logic u, input logic o);
    return {d, ~u, ~o, d[7]^d[6], d[5]^d[4], d[3]^d[2], d[1]^d[0], 2'b01};
  endfunction

  // Driver: pushes expected bits, runs one frame of nclk serial clocks.
  task automatic send(input logic [7:0] d, input logic u, input logic o, input logic sm,
                      input int nclk, input logic [7:0] d_mid, input bit mid_change);
    logic [15:0] f;
    int flen;
    f = sm ? {d, 8'h00} : long_frame(d, u, o);
    flen = sm ? 8 : 16;
    for (int i = 0; i < nclk; i++) begin
      exp_t e;
      e.v = (i < flen) ? f[15-i] : 1'b0;
      if (i >= flen)            e.tag = "R10";
      else if (nclk < flen)     e.tag = "R12";
      else if (mid_change)      e.tag = "R11";
      else if (sm)              e.tag = "R9";
      else if (i < 8)           e.tag = "R5";
      else if (i < 10)          e.tag = "R6";
      else if (i < 14)          e.tag = "R7";
      else                      e.tag = "R8";
      q.push_back(e);
    end
    short_m = sm; din = d; uv = u; ot = o;
    waitc(2);
    cs_n = 1'b0;
    waitc(4);
    check(miso_oe === 1'b1 && miso === d[7], "R3", {miso_oe, miso}, {1'b1, d[7]});
    if (mid_change) begin din = d_mid; uv = ~u; ot = ~o; end
    waitc(2);
    for (int i = 0; i < nclk; i++) begin
      sck = 1'b1; waitc(HALF_SCK);
      sck = 1'b0; waitc(HALF_SCK);
    end
    cs_n = 1'b1;
    waitc(4);
    check(miso_oe === 1'b0 && miso === 1'b0, "R2", {miso_oe, miso}, 2'b00);
    check(q.size() == 0, "R12", 2'(q.size()), 2'b00);
  endtask

  // Monitor: compares sampled bits against the queue.
  initial begin
    forever begin
      logic held;
      @(posedge sck);
      if (!cs_n) begin
        #1;
        if (q.size() == 0) begin
          check(1'b0, "R10", {miso_oe, miso}, 2'b00);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(miso_oe === 1'b1 && miso === e.v, e.tag, {miso_oe, miso}, {1'b1, e.v});
        end
        held = miso;
        @(negedge sck);
        check(miso === held, "R4", {1'b0, miso}, {1'b0, held});
      end
    end
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    waitc(3);
    check(miso_oe === 1'b0 && miso === 1'b0, "R1", {miso_oe, miso}, 2'b00);
    rst = 1'b0;
    waitc(1);
    check(miso_oe === 1'b0 && miso === 1'b0, "R1", {miso_oe, miso}, 2'b00);
    waitc(5);
    send(8'hA5, 1'b0, 1'b0, 1'b0, 16, 8'h00, 0);
    send(8'h3C, 1'b1, 1'b0, 1'b0, 16, 8'h00, 0);
    send(8'hF0, 1'b0, 1'b1, 1'b0, 16, 8'h00, 0);
    send(8'h81, 1'b1, 1'b1, 1'b0, 16, 8'h00, 0);
    send(8'hC9, 1'b1, 1'b1, 1'b1, 8, 8'h00, 0);
    send(8'h7E, 1'b0, 1'b0, 1'b1, 11, 8'h00, 0);
    send(8'h5A, 1'b0, 1'b1, 1'b0, 19, 8'h00, 0);
    send(8'h96, 1'b0, 1'b0, 1'b0, 16, 8'h69, 1);
    send(8'hE7, 1'b1, 1'b0, 1'b0, 5, 8'h00, 0);
    send(8'h12, 1'b0, 1'b1, 1'b0, 16, 8'h00, 0);
    send(8'hFF, 1'b0, 1'b0, 1'b1, 3, 8'h00, 0);
    send(8'h00, 1'b1, 1'b1, 1'b0, 16, 8'h00, 0);
    waitc(10);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule